// File: doc/BRIEF.md
# Masked Indirect Table Access Controller

This block lets a host reach a 256-entry table of 48-bit words without mapping the table into the register space. The host stages one entry in three 16-bit data registers, sets three matching 16-bit mask registers and an entry index, and then writes one control word. That word names the target memory, gives the direction and sets a start bit. A read copies the whole entry into the data registers. A write changes only the entry bits whose mask bit is 0 and leaves the others as they were.

The table RAM takes one cycle to read. For that reason every transfer reads the entry first. A write then merges the staged data into the entry under the mask and writes it back on the next cycle. The start bit clears itself when the transfer has completed. A busy output, also visible in the control word, is high for the whole transfer. While busy is high the block ignores host register writes, so the staged values cannot change during a transfer.

Host register map (address: content): 0 control; 1 entry index; 2, 3, 4 data words 0, 1, 2; 5, 6, 7 mask words 0, 1, 2. Control word layout: bits 4..0 memory select, bit 5 start, bit 6 direction (1 = write, 0 = read), bit 7 busy (read-only). All other read bits are 0.

Top module: `mtab_xfer_ctrl`

## Requirements
- R1: After reset every host register reads 0, the start bit reads 0 and busy is 0.
- R2: A host write while busy is 0 stores the value, and it reads back at once from the same address. The index is at address 1 and holds 8 bits. Data word k is at address 2+k and mask word k is at address 5+k.
- R3: A write transfer updates only the entry bits whose mask bit is 0 with the staged data bit. Entry bits whose mask bit is 1 keep their old value. Data word k maps to entry bits 16k+15..16k.
- R4: A read transfer overwrites all 48 data-register bits with the entry, whatever the mask holds. The mask registers keep their values.
- R5: A transfer whose select field (control bits 4..0) is not 6 changes neither the table nor the data registers.
- R6: When the select field is 6, the start bit (control bit 5) reads 1 in the two cycles after the control write and 0 from the third cycle on. For any other select value it reads 1 for one cycle only.
- R7: The busy port and control bit 7 equal the start bit. A transfer's effect is visible at the latest three cycles after the control write.
- R8: While busy is 1, host writes to any register, the control word included, are ignored. The running transfer uses the values that were staged before it started.
- R9: Index values 0 through 255 each select a distinct entry, including both end values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data for host_addr |
| busy | output | 1 | Transfer in progress |

## Verification
The bench builds the block with its default parameters: three 16-bit words, 256 entries and select code 6. These values make both end indices, 0 and 255, reachable, along with a mask that differs in each word (half a word, a full word and nothing). A foreign select code, 5 or 7, shows that a skipped transfer lasts only one cycle. With a two-cycle transfer there is room for a host write to land in the middle of it, which checks that such writes are ignored while busy.

// File: rtl/mtab_pkg.sv
`timescale 1ns/1ps
package mtab_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_APPLY = 2'd2,
      ST_SKIP  = 2'd3
   } xfer_st_t;

   localparam int ADR_CTRL   = 0;
   localparam int ADR_INDEX  = 1;
   localparam int ADR_DATA0  = 2;
   localparam int CTL_START  = 5;
   localparam int CTL_DIR    = 6;
   localparam int CTL_BUSY   = 7;
endpackage

// File: rtl/mtab_ram.sv
`timescale 1ns/1ps
module mtab_ram #(
   parameter int DEPTH = 256,
   parameter int WIDTH = 48,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rd_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_q,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) rd_q <= mem[rd_addr];
   end
endmodule

// File: rtl/mtab_regs.sv
`timescale 1ns/1ps
module mtab_regs
   import mtab_pkg::*;
#(
   parameter int NUM_WORDS = 3,
   parameter int WORD_W    = 16,
   parameter int IDX_W     = 8,
   parameter int SEL_W     = 5,
   parameter int HOST_AW   = 3,
   localparam int ENT_W     = NUM_WORDS * WORD_W,
   localparam int MASK_BASE = ADR_DATA0 + NUM_WORDS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [WORD_W-1:0]  host_wdata,
   output logic [WORD_W-1:0]  host_rdata,
   input  logic               busy,
   input  logic               start_q,
   input  logic               load_en,
   input  logic [ENT_W-1:0]   load_data,
   output logic [IDX_W-1:0]   idx_q,
   output logic [SEL_W-1:0]   sel_q,
   output logic               dir_q,
   output logic [ENT_W-1:0]   data_flat,
   output logic [ENT_W-1:0]   mask_flat
);
   logic wr_ok;
   logic [WORD_W-1:0] data_q [NUM_WORDS];
   logic [WORD_W-1:0] mask_q [NUM_WORDS];

   assign wr_ok = host_we && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
         sel_q <= '0;
         dir_q <= 1'b0;
      end else if (wr_ok) begin
         if (host_addr == HOST_AW'(ADR_INDEX)) idx_q <= host_wdata[IDX_W-1:0];
         if (host_addr == HOST_AW'(ADR_CTRL)) begin
            sel_q <= host_wdata[SEL_W-1:0];
            dir_q <= host_wdata[CTL_DIR];
         end
      end
   end

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            data_q[k] <= '0;
            mask_q[k] <= '0;
         end else begin
            if (load_en)
               data_q[k] <= load_data[k*WORD_W +: WORD_W];
            else if (wr_ok && host_addr == HOST_AW'(ADR_DATA0 + k))
               data_q[k] <= host_wdata;
            if (wr_ok && host_addr == HOST_AW'(MASK_BASE + k))
               mask_q[k] <= host_wdata;
         end
      end
      assign data_flat[k*WORD_W +: WORD_W] = data_q[k];
      assign mask_flat[k*WORD_W +: WORD_W] = mask_q[k];
   end

   always_comb begin
      host_rdata = '0;
      if (host_addr == HOST_AW'(ADR_CTRL)) begin
         host_rdata[SEL_W-1:0] = sel_q;
         host_rdata[CTL_START] = start_q;
         host_rdata[CTL_DIR]   = dir_q;
         host_rdata[CTL_BUSY]  = busy;
      end else if (host_addr == HOST_AW'(ADR_INDEX)) begin
         host_rdata[IDX_W-1:0] = idx_q;
      end
      for (int k = 0; k < NUM_WORDS; k++) begin
         if (host_addr == HOST_AW'(ADR_DATA0 + k)) host_rdata = data_q[k];
         if (host_addr == HOST_AW'(MASK_BASE + k)) host_rdata = mask_q[k];
      end
   end
endmodule

// File: rtl/mtab_seq.sv
`timescale 1ns/1ps
module mtab_seq
   import mtab_pkg::*;
#(
   parameter int SEL_W    = 5,
   parameter int SEL_CODE = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic [SEL_W-1:0] req_sel,
   input  logic             dir_q,
   output logic             start_q,
   output logic             busy,
   output logic             ram_re,
   output logic             ram_we,
   output logic             load_en
);
   xfer_st_t st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         start_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (start_req) begin
               start_q <= 1'b1;
               st      <= (req_sel == SEL_W'(SEL_CODE)) ? ST_FETCH : ST_SKIP;
            end
            ST_FETCH: st <= ST_APPLY;
            default: begin
               st      <= ST_IDLE;
               start_q <= 1'b0;
            end
         endcase
      end
   end

   assign busy    = (st != ST_IDLE);
   assign ram_re  = (st == ST_FETCH);
   assign ram_we  = (st == ST_APPLY) && dir_q;
   assign load_en = (st == ST_APPLY) && !dir_q;
endmodule

// File: rtl/mtab_xfer_ctrl.sv
`timescale 1ns/1ps
module mtab_xfer_ctrl
   import mtab_pkg::*;
#(
   parameter int NUM_WORDS = 3,
   parameter int WORD_W    = 16,
   parameter int DEPTH     = 256,
   parameter int SEL_W     = 5,
   parameter int SEL_CODE  = 6,
   parameter int HOST_AW   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [WORD_W-1:0]  host_wdata,
   output logic [WORD_W-1:0]  host_rdata,
   output logic               busy
);
   localparam int ENT_W = NUM_WORDS * WORD_W;
   localparam int IDX_W = $clog2(DEPTH);

   if (HOST_AW < $clog2(ADR_DATA0 + 2*NUM_WORDS)) begin : g_chk_aw
      $error("host address too narrow for register map");
   end
   if (WORD_W < CTL_BUSY + 1 || WORD_W < IDX_W || SEL_W > CTL_START) begin : g_chk_w
      $error("word width cannot hold control or index fields");
   end
   if (SEL_CODE >= (1 << SEL_W)) begin : g_chk_sel
      $error("select code does not fit select field");
   end

   logic               start_q, start_req;
   logic               ram_re, ram_we, load_en, dir_q;
   logic [IDX_W-1:0]   idx_q;
   logic [SEL_W-1:0]   sel_q;
   logic [ENT_W-1:0]   data_flat, mask_flat, ram_q, ram_wdata;

   assign start_req = host_we && !busy && (host_addr == HOST_AW'(ADR_CTRL))
                      && host_wdata[CTL_START];

   mtab_regs #(
      .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W),
      .SEL_W(SEL_W), .HOST_AW(HOST_AW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
      .start_q(start_q), .load_en(load_en), .load_data(ram_q),
      .idx_q(idx_q), .sel_q(sel_q), .dir_q(dir_q),
      .data_flat(data_flat), .mask_flat(mask_flat)
   );

   mtab_seq #(.SEL_W(SEL_W), .SEL_CODE(SEL_CODE)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_req(start_req),
      .req_sel(host_wdata[SEL_W-1:0]), .dir_q(dir_q), .start_q(start_q),
      .busy(busy), .ram_re(ram_re), .ram_we(ram_we), .load_en(load_en)
   );

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_merge
      localparam int LO = k * WORD_W;
      assign ram_wdata[LO +: WORD_W] =
         (ram_q[LO +: WORD_W] & mask_flat[LO +: WORD_W]) |
         (data_flat[LO +: WORD_W] & ~mask_flat[LO +: WORD_W]);
   end

   mtab_ram #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_ram (
      .clk(clk), .rd_en(ram_re), .rd_addr(idx_q), .rd_q(ram_q),
      .wr_en(ram_we), .wr_addr(idx_q), .wr_data(ram_wdata)
   );
endmodule

// File: rtl/mtab_xfer_chk.sv
`timescale 1ns/1ps
module mtab_xfer_chk #(
   parameter int ENT_W    = 48,
   parameter int IDX_W    = 8,
   parameter int SEL_W    = 5,
   parameter int SEL_CODE = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_we,
   input logic             busy,
   input logic             start_q,
   input logic             ram_we,
   input logic             dir_q,
   input logic [SEL_W-1:0] sel_q,
   input logic [IDX_W-1:0] idx_q,
   input logic [ENT_W-1:0] ram_q,
   input logic [ENT_W-1:0] ram_wdata,
   input logic [ENT_W-1:0] mask_flat,
   input logic [ENT_W-1:0] data_flat
);
   logic [2:0] busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n)            busy_run <= '0;
      else if (!busy)        busy_run <= '0;
      else if (busy_run != 3'd7) busy_run <= busy_run + 3'd1;
   end

   // R7: busy tracks the start bit
   a_r7_busy_is_start: assert property (@(posedge clk) disable iff (!rst_n)
      busy == start_q);

   // R7: no transfer keeps busy high for more than two cycles
   a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= 3'd2);

   // R8: index cannot move while a transfer runs
   a_r8_index_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_we) |=> $stable(idx_q));

   // R5: only the configured select code writes the table
   a_r5_no_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (sel_q == SEL_W'(SEL_CODE)));

   // R3: masked bits of the written word equal the old entry
   a_r3_masked_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (((ram_wdata ^ ram_q) & mask_flat) == '0));

   // R4: a completed read leaves the fetched entry in the data registers
   a_r4_read_loads_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(dir_q) && ($past(sel_q) == SEL_W'(SEL_CODE)))
      |-> (data_flat == $past(ram_q)));
endmodule

bind mtab_xfer_ctrl mtab_xfer_chk #(
   .ENT_W(NUM_WORDS*WORD_W), .IDX_W($clog2(DEPTH)),
   .SEL_W(SEL_W), .SEL_CODE(SEL_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_we(host_we), .busy(busy),
   .start_q(start_q), .ram_we(ram_we), .dir_q(dir_q), .sel_q(sel_q),
   .idx_q(idx_q), .ram_q(ram_q), .ram_wdata(ram_wdata),
   .mask_flat(mask_flat), .data_flat(data_flat)
);

// File: tb/tb_mtab_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_mtab_xfer_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [2:0]  host_addr = 3'd0;
   logic [15:0] host_wdata = 16'd0;
   logic [15:0] host_rdata;
   logic        busy;
   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mtab_xfer_ctrl dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy)
   );

   // behavioural reference model
   logic [47:0] m_tab [256];
   logic [15:0] m_data [3];
   logic [15:0] m_mask [3];
   logic [7:0]  m_idx;
   logic [4:0]  m_sel;
   logic        m_dir, m_start;
   int          m_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 3; k++) begin m_data[k] = 0; m_mask[k] = 0; end
         m_idx = 0; m_sel = 0; m_dir = 0; m_start = 0; m_cnt = 0;
      end else if (m_cnt > 0) begin
         m_cnt--;
         if (m_cnt == 0) begin
            if (m_sel == 5'd6) begin
               if (m_dir) begin
                  for (int k = 0; k < 3; k++)
                     for (int b = 0; b < 16; b++)
                        if (!m_mask[k][b]) m_tab[m_idx][16*k+b] = m_data[k][b];
               end else begin
                  for (int k = 0; k < 3; k++) m_data[k] = m_tab[m_idx][16*k +: 16];
               end
            end
            m_start = 0;
         end
      end else if (host_we) begin
         case (host_addr)
            3'd0: begin
               m_sel = host_wdata[4:0]; m_dir = host_wdata[6];
               if (host_wdata[5]) begin
                  m_start = 1; m_cnt = (m_sel == 5'd6) ? 2 : 1;
               end
            end
            3'd1: m_idx = host_wdata[7:0];
            3'd2, 3'd3, 3'd4: m_data[host_addr-2] = host_wdata;
            default: m_mask[host_addr-5] = host_wdata;
         endcase
      end
   end

   function automatic logic [15:0] model_rd(input logic [2:0] a);
      case (a)
         3'd0: model_rd = {8'd0, m_start, m_dir, m_start, m_sel};
         3'd1: model_rd = {8'd0, m_idx};
         3'd2, 3'd3, 3'd4: model_rd = m_data[a-2];
         default: model_rd = m_mask[a-5];
      endcase
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model (R2 readback, R7 busy)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R7 busy vs model", {15'd0, busy}, {15'd0, m_start});
         check("R2 readback vs model", host_rdata, model_rd(host_addr));
      end
   end

   task automatic hw(input logic [2:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(posedge clk); #1;
      host_we = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [15:0] v);
      @(posedge clk); #1;
      host_addr = a;
      @(negedge clk);
      v = host_rdata;
   endtask

   task automatic go(input logic [4:0] sel, input logic dir);
      hw(3'd0, {9'd0, dir, 1'b1, sel});
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic stage(input logic [47:0] e);
      hw(3'd2, e[15:0]); hw(3'd3, e[31:16]); hw(3'd4, e[47:32]);
   endtask

   task automatic masks(input logic [15:0] m0, input logic [15:0] m1, input logic [15:0] m2);
      hw(3'd5, m0); hw(3'd6, m1); hw(3'd7, m2);
   endtask

   task automatic expect_data(input string tag, input logic [47:0] e);
      logic [15:0] v;
      peek(3'd2, v); check(tag, v, e[15:0]);
      peek(3'd3, v); check(tag, v, e[31:16]);
      peek(3'd4, v); check(tag, v, e[47:32]);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         bad++;
         checks++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   localparam logic [47:0] PAT_A = 48'hC3A5_0F1E_7B29;
   localparam logic [47:0] PAT_B = 48'h5A5A_9001_E7C4;
   localparam logic [47:0] PAT_C = 48'h0001_8000_FFFE;
   localparam logic [47:0] PAT_D = 48'hFFFF_1357_2468;

   initial begin
      logic [15:0] v;
      logic [47:0] merged;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         peek(3'(a), v); check("R1 reset value", v, 16'd0);
      end
      check("R1 busy at reset", {15'd0, busy}, 16'd0);

      // R2: register write and readback
      hw(3'd1, 16'd5);
      peek(3'd1, v); check("R2 index readback", v, 16'd5);
      hw(3'd6, 16'hA5C3);
      peek(3'd6, v); check("R2 mask1 readback", v, 16'hA5C3);

      // unmasked write of entry 5, then R4 read with all mask bits set
      masks(16'h0, 16'h0, 16'h0);
      stage(PAT_A);
      go(5'd6, 1'b1);
      stage(48'h0);
      masks(16'hFFFF, 16'hFFFF, 16'hFFFF);
      go(5'd6, 1'b0);
      expect_data("R4 read ignores mask", PAT_A);
      peek(3'd5, v); check("R4 mask kept after read", v, 16'hFFFF);

      // R3: masked write, half / full / none masked
      masks(16'h00FF, 16'hFFFF, 16'h0000);
      stage(~PAT_A);
      go(5'd6, 1'b1);
      stage(48'h0);
      go(5'd6, 1'b0);
      merged = {~PAT_A[47:32], PAT_A[31:16], (PAT_A[15:0] & 16'h00FF) | (~PAT_A[15:0] & 16'hFF00)};
      expect_data("R3 masked write", merged);

      // R6/R5: foreign select, start clears after one cycle, table untouched
      masks(16'h0, 16'h0, 16'h0);
      stage(PAT_B);
      hw(3'd0, 16'h0065);
      @(negedge clk);
      check("R6 start set, foreign select", host_rdata & 16'h0020, 16'h0020);
      check("R7 busy during foreign start", {15'd0, busy}, 16'd1);
      @(posedge clk); #1;
      @(negedge clk);
      check("R6 start cleared, foreign select", host_rdata & 16'h0020, 16'h0000);
      stage(PAT_C);
      go(5'd7, 1'b0);
      expect_data("R5 foreign read leaves data", PAT_C);
      go(5'd6, 1'b0);
      expect_data("R5 table unchanged by foreign write", merged);

      // R6/R7: start bit timing for the table select
      hw(3'd0, 16'h0026);
      @(negedge clk);
      check("R6 start cycle 1", host_rdata & 16'h00A0, 16'h00A0);
      @(posedge clk); #1;
      @(negedge clk);
      check("R6 start cycle 2", host_rdata & 16'h00A0, 16'h00A0);
      @(posedge clk); #1;
      @(negedge clk);
      check("R6 start cleared cycle 3", host_rdata & 16'h00A0, 16'h0000);
      check("R7 busy low after completion", {15'd0, busy}, 16'd0);

      // R8: writes during busy are ignored
      stage(PAT_B);
      hw(3'd0, 16'h0066);
      host_we = 1'b1; host_addr = 3'd1; host_wdata = 16'd77;
      @(posedge clk); #1;
      host_addr = 3'd2; host_wdata = 16'hBEEF;
      @(posedge clk); #1;
      host_we = 1'b0;
      peek(3'd1, v); check("R8 index kept during busy", v, 16'd5);
      peek(3'd2, v); check("R8 data kept during busy", v, PAT_B[15:0]);
      stage(48'h0);
      go(5'd6, 1'b0);
      expect_data("R8 transfer used staged data", PAT_B);

      // R9: both end indices
      hw(3'd1, 16'd0);   stage(PAT_C); go(5'd6, 1'b1);
      hw(3'd1, 16'd255); stage(PAT_D); go(5'd6, 1'b1);
      hw(3'd1, 16'd0);   go(5'd6, 1'b0);
      expect_data("R9 entry 0", PAT_C);
      hw(3'd1, 16'd255); go(5'd6, 1'b0);
      expect_data("R9 entry 255", PAT_D);
      hw(3'd1, 16'd5);   go(5'd6, 1'b0);
      expect_data("R9 entry 5 distinct", PAT_B);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule